// File: doc/BRIEF.md
# Zero-Extending Word Arithmetic Unit

This unit sits in the execute stage of a 64-bit RISC-V pipeline and handles five word-sized operations whose results are zero-extended instead of sign-extended. The issue logic presents one instruction word with its two 64-bit source operands and a valid strobe. The unit decodes the instruction and computes the result. One clock later it returns the 64-bit result, the destination register index and an illegal-instruction flag.

The five operations are a word add, a word subtract, an immediate word add, a mixed add that zero-extends only its first operand, and a left shift of a zero-extended word. All five depend on an extension-enable input. When that input is low, or when the word matches none of the five encodings, the unit raises the illegal flag and returns a zero result. The register file, operand forwarding and trap handling belong to the surrounding core.

Top module: `zext_word_alu`

## Requirements
- R1: Word add (opcode 0111011, funct3 000, funct7 0000101) returns bits 31:0 of rs1+rs2 with bits 63:32 zero. Any carry out of bit 31 is dropped.
- R2: Word subtract (opcode 0111011, funct3 000, funct7 0100101) returns bits 31:0 of rs1-rs2 with bits 63:32 zero.
- R3: Mixed add (opcode 0111011, funct3 000, funct7 0000100) zero-extends bits 31:0 of rs1, adds the full 64-bit rs2 and returns the 64-bit sum untruncated.
- R4: Immediate word add (opcode 0011011, funct3 100) sign-extends instruction bits 31:20 to 64 bits, adds it to rs1 and returns bits 31:0 of the sum zero-extended.
- R5: Word shift (opcode 0011011, funct3 001, bits 31:26 = 000010) zero-extends bits 31:0 of rs1 and shifts it left across 64 bits by the amount in instruction bits 25:20. Any shift from 0 to 63 is allowed.
- R6: When the extension enable is low in the capture cycle, all five operations raise the illegal flag.
- R7: An instruction word that matches none of the five encodings raises the illegal flag. Whenever the illegal flag is raised, the result is zero.
- R8: Result, destination index and illegal flag are captured on the rising edge at which the input valid is high. The output valid is the input valid delayed by one cycle. While the input valid is low, all captured outputs hold their values.
- R9: The destination index output is instruction bits 11:7 of the captured instruction, illegal or not.
- R10: An asynchronous active-low reset clears the output valid, the result, the index and the illegal flag to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_en_i | input | 1 | Extension enable; low makes all five operations illegal |
| in_valid_i | input | 1 | Instruction and operands are valid this cycle |
| insn_i | input | 32 | Instruction word |
| rs1_i | input | 64 | First source operand |
| rs2_i | input | 64 | Second source operand |
| out_valid_o | output | 1 | Registered outputs hold a new result |
| result_o | output | 64 | Registered result |
| rd_o | output | 5 | Registered destination register index |
| illegal_o | output | 1 | Registered illegal-instruction flag |

## Verification
In one capture cycle the decoder can recognise a valid encoding while the extension gate rejects it. The gate must win, giving an illegal flag and a zero result instead of the arithmetic value. The bench sends back-to-back vectors that reuse the same legal instruction words while the enable toggles from one vector to the next. The scoreboard then checks that each output matches its own cycle's enable, so no legal result leaks from the neighbouring vector. Separately, the valid strobe is dropped after a result to confirm that the outputs hold and do not follow the changing inputs.

// File: rtl/zw_pkg.sv
package zw_pkg;

  localparam logic [6:0] OPC_WORD_REG = 7'b0111011;
  localparam logic [6:0] OPC_WORD_IMM = 7'b0011011;

  localparam logic [6:0] F7_ADD_ZW    = 7'b0000101;
  localparam logic [6:0] F7_SUB_ZW    = 7'b0100101;
  localparam logic [6:0] F7_ADD_MIX   = 7'b0000100;
  localparam logic [5:0] F6_SHL_ZW    = 6'b000010;

  localparam logic [2:0] F3_REG_ARITH = 3'b000;
  localparam logic [2:0] F3_IMM_ADD   = 3'b100;
  localparam logic [2:0] F3_SHL       = 3'b001;

  typedef enum logic [2:0] {
    ZOP_NONE   = 3'd0,
    ZOP_ADD_ZW = 3'd1,
    ZOP_SUB_ZW = 3'd2,
    ZOP_ADD_MX = 3'd3,
    ZOP_ADDI_Z = 3'd4,
    ZOP_SHL_ZW = 3'd5
  } zop_e;

  typedef struct packed {
    zop_e        op;
    logic        illegal;
    logic [4:0]  rd;
    logic [11:0] imm;
    logic [5:0]  shamt;
  } zdec_t;

endpackage

// File: rtl/zw_decoder.sv
module zw_decoder
  import zw_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic        ext_en_i,
  output zdec_t       dec_o
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic [5:0] f6;
  zop_e       raw_op;

  assign opc = insn_i[6:0];
  assign f3  = insn_i[14:12];
  assign f7  = insn_i[31:25];
  assign f6  = insn_i[31:26];

  always_comb begin
    raw_op = ZOP_NONE;
    if (opc == OPC_WORD_REG && f3 == F3_REG_ARITH) begin
      unique case (f7)
        F7_ADD_ZW:  raw_op = ZOP_ADD_ZW;
        F7_SUB_ZW:  raw_op = ZOP_SUB_ZW;
        F7_ADD_MIX: raw_op = ZOP_ADD_MX;
        default:    raw_op = ZOP_NONE;
      endcase
    end else if (opc == OPC_WORD_IMM && f3 == F3_IMM_ADD) begin
      raw_op = ZOP_ADDI_Z;
    end else if (opc == OPC_WORD_IMM && f3 == F3_SHL && f6 == F6_SHL_ZW) begin
      raw_op = ZOP_SHL_ZW;
    end
  end

  always_comb begin
    dec_o.rd    = insn_i[11:7];
    dec_o.imm   = insn_i[31:20];
    dec_o.shamt = insn_i[25:20];
    if (raw_op == ZOP_NONE || !ext_en_i) begin
      dec_o.op      = ZOP_NONE;
      dec_o.illegal = 1'b1;
    end else begin
      dec_o.op      = raw_op;
      dec_o.illegal = 1'b0;
    end
  end

endmodule

// File: rtl/zw_shifter.sv
module zw_shifter #(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] val_i,
  input  logic [SHW-1:0]  amt_i,
  output logic [XLEN-1:0] val_o
);

  logic [XLEN-1:0] stage [SHW+1];

  assign stage[0] = val_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    assign stage[k+1] = amt_i[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  assign val_o = stage[SHW];

endmodule

// File: rtl/zw_datapath.sv
module zw_datapath
  import zw_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  zdec_t           dec_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic [XLEN-1:0] result_o
);

  logic [XLEN-1:0] rs1_zw;
  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] opa;
  logic [XLEN-1:0] opb;
  logic            sub;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] sum_zw;
  logic [XLEN-1:0] shl;

  assign rs1_zw = {{(XLEN-WLEN){1'b0}}, rs1_i[WLEN-1:0]};
  assign imm_sx = {{(XLEN-12){dec_i.imm[11]}}, dec_i.imm};

  always_comb begin
    sub = (dec_i.op == ZOP_SUB_ZW);
    opa = (dec_i.op == ZOP_ADD_MX) ? rs1_zw : rs1_i;
    unique case (dec_i.op)
      ZOP_ADDI_Z: opb = imm_sx;
      ZOP_SUB_ZW: opb = ~rs2_i;
      default:    opb = rs2_i;
    endcase
  end

  assign sum    = opa + opb + {{(XLEN-1){1'b0}}, sub};
  assign sum_zw = {{(XLEN-WLEN){1'b0}}, sum[WLEN-1:0]};

  zw_shifter #(.XLEN(XLEN)) shl_i (
    .val_i (rs1_zw),
    .amt_i (dec_i.shamt[SHW-1:0]),
    .val_o (shl)
  );

  always_comb begin
    unique case (dec_i.op)
      ZOP_ADD_ZW, ZOP_SUB_ZW, ZOP_ADDI_Z: result_o = sum_zw;
      ZOP_ADD_MX:                         result_o = sum;
      ZOP_SHL_ZW:                         result_o = shl;
      default:                            result_o = '0;
    endcase
  end

endmodule

// File: rtl/zw_out_reg.sv
module zw_out_reg #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [XLEN-1:0] result_i,
  input  logic [4:0]      rd_i,
  input  logic            illegal_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o,
  output logic [4:0]      rd_o,
  output logic            illegal_o
);

  logic            valid_d;
  logic [XLEN-1:0] result_d;
  logic [4:0]      rd_d;
  logic            illegal_d;

  always_comb begin
    valid_d   = en_i;
    result_d  = result_o;
    rd_d      = rd_o;
    illegal_d = illegal_o;
    if (en_i) begin
      result_d  = result_i;
      rd_d      = rd_i;
      illegal_d = illegal_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      rd_o      <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= valid_d;
      result_o  <= result_d;
      rd_o      <= rd_d;
      illegal_o <= illegal_d;
    end
  end

endmodule

// File: rtl/zext_word_alu.sv
module zext_word_alu
  import zw_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_en_i,
  input  logic            in_valid_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic            out_valid_o,
  output logic [XLEN-1:0] result_o,
  output logic [4:0]      rd_o,
  output logic            illegal_o
);

  zdec_t           dec;
  logic [XLEN-1:0] alu_res;

  zw_decoder dec_i (
    .insn_i   (insn_i),
    .ext_en_i (ext_en_i),
    .dec_o    (dec)
  );

  zw_datapath #(.XLEN(XLEN), .WLEN(WLEN)) dp_i (
    .dec_i    (dec),
    .rs1_i    (rs1_i),
    .rs2_i    (rs2_i),
    .result_o (alu_res)
  );

  zw_out_reg #(.XLEN(XLEN)) oreg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (in_valid_i),
    .result_i  (alu_res),
    .rd_i      (dec.rd),
    .illegal_i (dec.illegal),
    .valid_o   (out_valid_o),
    .result_o  (result_o),
    .rd_o      (rd_o),
    .illegal_o (illegal_o)
  );

endmodule

// File: rtl/zw_checker.sv
module zw_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ext_en_i,
  input logic            in_valid_i,
  input logic [31:0]     insn_i,
  input logic            out_valid_o,
  input logic [XLEN-1:0] result_o,
  input logic [4:0]      rd_o,
  input logic            illegal_o
);

  logic word_reg_op;
  assign word_reg_op = (insn_i[6:0] == 7'b0111011) && (insn_i[14:12] == 3'b000) &&
                       ((insn_i[31:25] == 7'b0000101) || (insn_i[31:25] == 7'b0100101));

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o); // R8
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ($stable(result_o) && $stable(rd_o) && $stable(illegal_o))); // R8
  AST_EXT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !ext_en_i) |=> illegal_o); // R6
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && illegal_o) |-> (result_o == '0)); // R7
  AST_WORD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && ext_en_i && word_reg_op) |=> (result_o[XLEN-1:32] == '0 && !illegal_o)); // R1
  AST_RD_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> (rd_o == $past(insn_i[11:7]))); // R9

endmodule

bind zext_word_alu zw_checker #(.XLEN(XLEN)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_en_i    (ext_en_i),
  .in_valid_i  (in_valid_i),
  .insn_i      (insn_i),
  .out_valid_o (out_valid_o),
  .result_o    (result_o),
  .rd_o        (rd_o),
  .illegal_o   (illegal_o)
);

// File: tb/zext_word_alu_tb_top.sv
module zext_word_alu_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] res;
    logic [4:0]  rd;
    logic        ill;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        ext_en;
  logic        in_valid;
  logic [31:0] insn;
  logic [63:0] rs1;
  logic [63:0] rs2;
  logic        out_valid;
  logic [63:0] result;
  logic [4:0]  rd;
  logic        illegal;

  int   n_checks = 0;
  int   n_fails  = 0;
  exp_t sb_q[$];
  bit   finished = 0;

  zext_word_alu dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_en_i    (ext_en),
    .in_valid_i  (in_valid),
    .insn_i      (insn),
    .rs1_i       (rs1),
    .rs2_i       (rs2),
    .out_valid_o (out_valid),
    .result_o    (result),
    .rd_o        (rd),
    .illegal_o   (illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // kinds: 0 add word, 1 sub word, 2 mixed add, 3 imm add, 4 shift, 5 raw word
  function automatic logic [63:0] model(int k, logic [63:0] a, logic [63:0] b,
                                        logic [11:0] imm, logic [5:0] sh);
    logic [63:0] t;
    case (k)
      0: begin t = a + b; return {32'h0, t[31:0]}; end
      1: begin t = a - b; return {32'h0, t[31:0]}; end
      2: return {32'h0, a[31:0]} + b;
      3: begin t = a + {{52{imm[11]}}, imm}; return {32'h0, t[31:0]}; end
      4: return {32'h0, a[31:0]} << sh;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [31:0] encode(int k, logic [4:0] rdi, logic [11:0] imm, logic [5:0] sh);
    case (k)
      0: return {7'b0000101, 5'd3, 5'd2, 3'b000, rdi, 7'b0111011};
      1: return {7'b0100101, 5'd3, 5'd2, 3'b000, rdi, 7'b0111011};
      2: return {7'b0000100, 5'd3, 5'd2, 3'b000, rdi, 7'b0111011};
      3: return {imm, 5'd2, 3'b100, rdi, 7'b0011011};
      default: return {6'b000010, sh, 5'd2, 3'b001, rdi, 7'b0011011};
    endcase
  endfunction

  task automatic send_raw(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                          input logic en, input logic [63:0] eres, input logic eill, input string tag);
    exp_t e;
    @(negedge clk);
    insn = w; rs1 = a; rs2 = b; ext_en = en; in_valid = 1'b1;
    e.res = eres; e.rd = w[11:7]; e.ill = eill; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic send_op(input int k, input logic [4:0] rdi, input logic [63:0] a,
                         input logic [63:0] b, input logic [11:0] imm, input logic [5:0] sh,
                         input logic en, input string tag);
    logic [31:0] w;
    w = encode(k, rdi, imm, sh);
    if (k == 4) w[25:20] = sh;
    if (en) send_raw(w, a, b, en, model(k, a, b, imm, sh), 1'b0, tag);
    else    send_raw(w, a, b, en, 64'h0, 1'b1, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      insn = $urandom; rs1 = {$urandom, $urandom}; rs2 = {$urandom, $urandom};
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && out_valid) begin
        exp_t e;
        if (sb_q.size() == 0) begin
          n_checks++; n_fails++;
          $display("FAIL R8: actual unexpected result expected none");
        end else begin
          e = sb_q.pop_front();
          check({e.tag, " result"}, result, e.res);
          check({e.tag, " illegal"}, {63'h0, illegal}, {63'h0, e.ill});
          check("R9 rd", {59'h0, rd}, {59'h0, e.rd});
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    rst_n = 1'b0; in_valid = 1'b0; ext_en = 1'b1;
    insn = 32'h0; rs1 = 64'h0; rs2 = 64'h0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", {63'h0, out_valid}, 64'h0);
    check("R10 result", result, 64'h0);
    check("R10 illegal", {63'h0, illegal}, 64'h0);
    rst_n = 1'b1;
    idle(2);

    // R1 carry out of bit 31 dropped, upper input bits ignored
    send_op(0, 5'd1, 64'hDEAD_0000_FFFF_FFFF, 64'h1, 12'h0, 6'd0, 1'b1, "R1 carry");
    send_op(0, 5'd4, 64'h1234_5678_0000_0010, 64'hFFFF_0000_0000_0020, 12'h0, 6'd0, 1'b1, "R1 plain");
    // R2 borrow below zero
    send_op(1, 5'd5, 64'h0, 64'h1, 12'h0, 6'd0, 1'b1, "R2 borrow");
    send_op(1, 5'd6, 64'h0000_0001_0000_0005, 64'h3, 12'h0, 6'd0, 1'b1, "R2 plain");
    // R3 all-ones rs1, full-width sum
    send_op(2, 5'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 12'h0, 6'd0, 1'b1, "R3 ones");
    send_op(2, 5'd8, 64'h8000_0000_8000_0000, 64'hFFFF_FFFF_0000_0000, 12'h0, 6'd0, 1'b1, "R3 wide");
    // R4 negative and positive immediates
    send_op(3, 5'd9, 64'h0, 64'h0, 12'hFFF, 6'd0, 1'b1, "R4 neg");
    send_op(3, 5'd10, 64'h0000_0003_7FFF_FFFF, 64'h0, 12'h001, 6'd0, 1'b1, "R4 pos");
    // R5 shift amounts 0, 32, 63
    send_op(4, 5'd11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 12'h0, 6'd0, 1'b1, "R5 sh0");
    send_op(4, 5'd12, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 12'h0, 6'd32, 1'b1, "R5 sh32");
    send_op(4, 5'd13, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 12'h0, 6'd63, 1'b1, "R5 sh63");
    // R6 gate toggling back to back on the same legal words
    for (int k = 0; k < 5; k++) begin
      send_op(k, 5'(14 + k), 64'hFFFF_FFFF, 64'h2, 12'h7FF, 6'd4, 1'b0, "R6 off");
      send_op(k, 5'(20 + k), 64'hFFFF_FFFF, 64'h2, 12'h7FF, 6'd4, 1'b1, "R6 on");
    end
    // R7 unrecognised words
    send_raw({7'b0000000, 5'd3, 5'd2, 3'b000, 5'd25, 7'b0111011}, 64'h5, 64'h6, 1'b1, 64'h0, 1'b1, "R7 funct7");
    send_raw({6'b000011, 6'd3, 5'd2, 3'b001, 5'd26, 7'b0011011}, 64'h5, 64'h6, 1'b1, 64'h0, 1'b1, "R7 shtop");
    send_raw({7'b0000101, 5'd3, 5'd2, 3'b000, 5'd27, 7'b0110011}, 64'h5, 64'h6, 1'b1, 64'h0, 1'b1, "R7 opcode");
    send_raw({7'b0000101, 5'd3, 5'd2, 3'b010, 5'd28, 7'b0111011}, 64'h5, 64'h6, 1'b1, 64'h0, 1'b1, "R7 funct3");

    // R8 outputs hold while valid is low
    send_op(0, 5'd30, 64'h10, 64'h20, 12'h0, 6'd0, 1'b1, "R8 last");
    held = 64'h30;
    idle(4);
    check("R8 hold result", result, held);
    check("R8 hold valid", {63'h0, out_valid}, 64'h0);
    check("R8 hold rd", {59'h0, rd}, 64'd30);

    // random operands on all five operations
    for (int i = 0; i < 300; i++) begin
      int k;
      k = $urandom_range(0, 4);
      send_op(k, 5'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
              12'($urandom), 6'($urandom), 1'b1, "R1-5 random");
      if ($urandom_range(0, 7) == 0) idle(1);
    end
    idle(3);
    check("R8 drained", 64'(sb_q.size()), 64'h0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule